// File: doc/BRIEF.md
# I/O Port Access Decoder

This block turns one processor-side request into a device-side access in a separate 16-bit I/O space that has no connection to memory. The request carries a port address, an access size of one, two or four bytes, a read/write flag, a flag marking the direct (8-bit address) instruction form, and a valid strobe. Byte ports may sit at any address. Word ports must start on an even address. Doubleword ports must start on an address that is a multiple of four. The lower 256 addresses form page 0, and the direct form may only reach those. The eight ports at 0x00F8 to 0x00FF are reserved.

If a request passes every check, the block drives a device strobe, a one-hot device select, a doubleword-aligned device address and 4 byte-lane enables in the same cycle. It also places the write data on the addressed lanes. One cycle later it returns a registered response. The response holds the read data, shifted down to bit 0, plus flags for misalignment, a direct-form range violation, a reserved-port hit, and whether the address lies in page 0. A request that fails any check never strobes a device.

Top module: `io_port_decoder`

## Requirements
- R1: Size code 00 is byte, 01 is word and 10 is doubleword. On an accepted access, `dev_lane_en` is the size's byte mask (0001, 0011 or 1111) shifted left by address bits [1:0], with lane 0 the least significant byte. The enables are zero when no access is accepted.
- R2: The following raise `rsp_err_align` and produce no `dev_stb`: size code 11, a word at an odd address, or a doubleword whose address bits [1:0] are not 00.
- R3: Any access whose address lies in 0x00F8 to 0x00FF raises `rsp_err_resv` and produces no `dev_stb`.
- R4: A direct-form request (`req_direct`=1) above 0x00FF raises `rsp_err_range` and produces no `dev_stb`. A non-direct request may use any address.
- R5: `rsp_page0` is 1 exactly when the request address is at most 0x00FF. This holds whether or not the request is accepted.
- R6: On an accepted access, lane k of `dev_wdata` carries request write byte (k minus address bits [1:0]) if lane k is enabled, and 0 otherwise. `dev_wdata` is all zero when no access is accepted. `dev_we` equals `req_write` on accepted accesses.
- R7: `rsp_rdata` holds the enabled lanes of `dev_rdata`, moved down so the lowest enabled lane lands at bits [7:0], with the upper bytes zero. It is all zero for writes and for rejected requests.
- R8: `rsp_valid` and the response fields change exactly one clock after a cycle with `req_valid` high. `rsp_valid` is low, and every flag is zero, after a cycle without a request.
- R9: On an accepted access, `dev_sel` is one-hot and selects device number address bits [5:4], and `dev_addr` is the request address with bits [1:0] cleared. Both are zero otherwise.
- R10: During and right after reset, `rsp_valid`, all response flags and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 16 | Port address |
| req_size | input | 2 | 00 byte, 01 word, 10 doubleword, 11 illegal |
| req_write | input | 1 | 1 for write, 0 for read |
| req_direct | input | 1 | Direct (page-0 only) addressing form |
| req_wdata | input | 32 | Write data, right-justified |
| dev_stb | output | 1 | Device access strobe |
| dev_we | output | 1 | Device write enable |
| dev_addr | output | 16 | Doubleword-aligned device address |
| dev_lane_en | output | 4 | Byte-lane enables |
| dev_sel | output | 4 | One-hot device select |
| dev_wdata | output | 32 | Lane-placed write data |
| dev_rdata | input | 32 | Device read data, all lanes |
| rsp_valid | output | 1 | Response valid |
| rsp_err_align | output | 1 | Misaligned or illegal size |
| rsp_err_range | output | 1 | Direct form outside page 0 |
| rsp_err_resv | output | 1 | Reserved port hit |
| rsp_page0 | output | 1 | Address lies in page 0 |
| rsp_rdata | output | 32 | Right-justified read data |

## Verification
The bench sweeps every address in the first 320 ports, plus windows at the top of the space and around 0x8000. It covers every size code, both addressing forms and both directions. Several boundaries get particular attention. Around 0x00F7/0x00F8 and 0x00FF/0x0100, an off-by-one would leak a reserved port to a device or wrongly refuse a legal one. Across odd and unaligned offsets, a weak alignment test would strobe a device with split lanes. For byte and word reads at lanes 1 to 3, a missing shift would return data in the wrong byte or leave stale upper bytes.

// File: rtl/io_dec_pkg.sv
`timescale 1ns/1ps
package io_dec_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_BAD   = 2'b11
    } io_size_e;
endpackage

// File: rtl/io_align_check.sv
`timescale 1ns/1ps
module io_align_check #(
    parameter int LANES = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  io_dec_pkg::io_size_e size,
    input  logic [IDX_W-1:0]     addr_lo,
    output logic                 misalign,
    output logic [LANES-1:0]     lane_mask
);
    import io_dec_pkg::*;

    int lo_i;
    int nb_i;

    always_comb begin : b_size
        lo_i = int'(addr_lo);
        case (size)
            SZ_BYTE:  nb_i = 1;
            SZ_WORD:  nb_i = 2;
            SZ_DWORD: nb_i = 4;
            default:  nb_i = 0;
        endcase
        misalign = (nb_i == 0) || (nb_i > LANES) || ((lo_i & (nb_i - 1)) != 0);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_mask[k] = !misalign && (k >= lo_i) && (k < lo_i + nb_i);
    end
endmodule

// File: rtl/io_space_check.sv
`timescale 1ns/1ps
module io_space_check #(
    parameter int              ADDR_W    = 16,
    parameter int              PAGE_BITS = 8,
    parameter int              RESV_LOG  = 3,
    parameter logic [ADDR_W-1:0] RESV_BASE = 'h00F8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              direct,
    output logic              in_page0,
    output logic              resv_hit,
    output logic              range_err
);
    localparam logic [ADDR_W-RESV_LOG-1:0] RESV_TAG = RESV_BASE[ADDR_W-1:RESV_LOG];

    always_comb begin
        in_page0  = (addr[ADDR_W-1:PAGE_BITS] == '0);
        resv_hit  = (addr[ADDR_W-1:RESV_LOG] == RESV_TAG);
        range_err = direct && !in_page0;
    end
endmodule

// File: rtl/io_lane_mux.sv
`timescale 1ns/1ps
module io_lane_mux #(
    parameter int LANES = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int DATA_W = LANES * 8
) (
    input  logic [IDX_W-1:0]  addr_lo,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [DATA_W-1:0] wdata_lanes,
    output logic [DATA_W-1:0] rdata_just
);
    int lo_i;
    assign lo_i = int'(addr_lo);

    for (genvar k = 0; k < LANES; k++) begin : g_wr
        assign wdata_lanes[8*k +: 8] =
            (lane_mask[k] && (k >= lo_i)) ? wdata_in[8*(k - lo_i) +: 8] : 8'h00;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_rd
        assign rdata_just[8*j +: 8] =
            ((j + lo_i < LANES) && lane_mask[j + lo_i]) ? rdata_in[8*(j + lo_i) +: 8] : 8'h00;
    end
endmodule

// File: rtl/io_port_decoder.sv
`timescale 1ns/1ps
module io_port_decoder #(
    parameter int                ADDR_W    = 16,
    parameter int                LANES     = 4,
    parameter int                PAGE_BITS = 8,
    parameter int                RESV_LOG  = 3,
    parameter logic [ADDR_W-1:0] RESV_BASE = 'h00F8,
    parameter int                NUM_DEV   = 4,
    parameter int                SEL_LSB   = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int DATA_W = LANES * 8,
    localparam int SEL_W  = $clog2(NUM_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_direct,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              dev_stb,
    output logic              dev_we,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [LANES-1:0]  dev_lane_en,
    output logic [NUM_DEV-1:0] dev_sel,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              rsp_valid,
    output logic              rsp_err_align,
    output logic              rsp_err_range,
    output logic              rsp_err_resv,
    output logic              rsp_page0,
    output logic [DATA_W-1:0] rsp_rdata
);
    import io_dec_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              err_align;
        logic              err_range;
        logic              err_resv;
        logic              page0;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic              misalign;
    logic [LANES-1:0]  lane_mask;
    logic              in_page0, resv_hit, range_err;
    logic [DATA_W-1:0] wdata_lanes, rdata_just;
    logic              accept;

    io_align_check #(.LANES(LANES)) u_align (
        .size      (io_size_e'(req_size)),
        .addr_lo   (req_addr[IDX_W-1:0]),
        .misalign  (misalign),
        .lane_mask (lane_mask)
    );

    io_space_check #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .RESV_LOG(RESV_LOG), .RESV_BASE(RESV_BASE)
    ) u_space (
        .addr      (req_addr),
        .direct    (req_direct),
        .in_page0  (in_page0),
        .resv_hit  (resv_hit),
        .range_err (range_err)
    );

    io_lane_mux #(.LANES(LANES)) u_mux (
        .addr_lo     (req_addr[IDX_W-1:0]),
        .lane_mask   (lane_mask),
        .wdata_in    (req_wdata),
        .rdata_in    (dev_rdata),
        .wdata_lanes (wdata_lanes),
        .rdata_just  (rdata_just)
    );

    assign accept = req_valid && !misalign && !resv_hit && !range_err;

    // device side, same cycle as the request
    always_comb begin
        dev_stb     = accept;
        dev_we      = accept && req_write;
        dev_addr    = accept ? {req_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}} : '0;
        dev_lane_en = accept ? lane_mask : '0;
        dev_wdata   = accept ? wdata_lanes : '0;
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign dev_sel[i] = accept && (req_addr[SEL_LSB +: SEL_W] == SEL_W'(i));
    end

    // next-state of the registered response
    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid     = 1'b1;
            rsp_d.err_align = misalign;
            rsp_d.err_range = range_err;
            rsp_d.err_resv  = resv_hit;
            rsp_d.page0     = in_page0;
            if (accept && !req_write) begin
                rsp_d.rdata = rdata_just;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_err_align = rsp_q.err_align;
    assign rsp_err_range = rsp_q.err_range;
    assign rsp_err_resv  = rsp_q.err_resv;
    assign rsp_page0     = rsp_q.page0;
    assign rsp_rdata     = rsp_q.rdata;
endmodule

// File: rtl/io_port_decoder_chk.sv
`timescale 1ns/1ps
module io_port_decoder_chk #(
    parameter int ADDR_W  = 16,
    parameter int LANES   = 4,
    parameter int NUM_DEV = 4,
    localparam int DATA_W = LANES * 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               dev_stb,
    input logic [ADDR_W-1:0]  dev_addr,
    input logic [LANES-1:0]   dev_lane_en,
    input logic [NUM_DEV-1:0] dev_sel,
    input logic               rsp_valid,
    input logic               rsp_err_align,
    input logic               rsp_err_range,
    input logic               rsp_err_resv,
    input logic               rsp_page0,
    input logic [DATA_W-1:0]  rsp_rdata
);
    p_strobe_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_stb |=> rsp_valid && !rsp_err_align && !rsp_err_resv && !rsp_err_range);

    p_reject_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dev_stb) |=> rsp_valid && (rsp_err_align || rsp_err_resv || rsp_err_range));

    p_idle_no_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_err_align && !rsp_err_range && !rsp_err_resv);

    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_stb |-> ($countones(dev_sel) == 1) && (dev_addr[1:0] == 2'b00));

    p_quiet_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_stb |-> (dev_lane_en == '0) && (dev_sel == '0));

    p_rdata_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_err_align || rsp_err_range || rsp_err_resv || $past(req_write)))
            |-> (rsp_rdata == '0));

    p_range_offpage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_range |-> !rsp_page0);
endmodule

bind io_port_decoder io_port_decoder_chk #(
    .ADDR_W(ADDR_W), .LANES(LANES), .NUM_DEV(NUM_DEV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .dev_stb(dev_stb), .dev_addr(dev_addr), .dev_lane_en(dev_lane_en), .dev_sel(dev_sel),
    .rsp_valid(rsp_valid), .rsp_err_align(rsp_err_align), .rsp_err_range(rsp_err_range),
    .rsp_err_resv(rsp_err_resv), .rsp_page0(rsp_page0), .rsp_rdata(rsp_rdata)
);

// File: tb/io_port_decoder_tb.sv
`timescale 1ns/1ps
module io_port_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_direct = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        dev_stb, dev_we;
    logic [15:0] dev_addr;
    logic [3:0]  dev_lane_en, dev_sel;
    logic [31:0] dev_wdata, dev_rdata;
    logic        rsp_valid, rsp_err_align, rsp_err_range, rsp_err_resv, rsp_page0;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    logic [15:0] cur_a;

    always #4 clk = ~clk;

    function automatic logic [31:0] dev_model(input logic [15:0] aa);
        return {aa[7:0] + 8'h33, ~aa[7:0], aa[15:8] ^ 8'h5A, aa[7:0]};
    endfunction

    assign dev_rdata = dev_model(dev_addr);

    io_port_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_direct(req_direct),
        .req_wdata(req_wdata), .dev_stb(dev_stb), .dev_we(dev_we), .dev_addr(dev_addr),
        .dev_lane_en(dev_lane_en), .dev_sel(dev_sel), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .rsp_valid(rsp_valid), .rsp_err_align(rsp_err_align),
        .rsp_err_range(rsp_err_range), .rsp_err_resv(rsp_err_resv),
        .rsp_page0(rsp_page0), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, cur_a, act, exp);
        end
    endtask

    task automatic do_req(input logic [15:0] a, input logic [1:0] sz,
                          input logic dir, input logic wr);
        int nb, lo;
        logic mis, resv, rng, acc;
        logic [3:0] mask;
        logic [31:0] wd, ewd, erd, model;
        @(negedge clk);
        cur_a = a;
        chk("R8 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
        lo = int'(a[1:0]);
        mis  = (nb == 0) || ((lo % ((nb == 0) ? 1 : nb)) != 0);
        resv = (a >= 16'h00F8) && (a <= 16'h00FF);
        rng  = dir && (a > 16'h00FF);
        acc  = !mis && !resv && !rng;
        mask = acc ? 4'(((1 << nb) - 1) << lo) : 4'h0;
        wd   = 32'h9E37_79B9 ^ {a, ~a};
        ewd  = '0;
        for (int k = 0; k < 4; k++)
            if (mask[k]) ewd[8*k +: 8] = wd[8*(k - lo) +: 8];
        model = dev_model({a[15:2], 2'b00});
        erd = '0;
        if (acc && !wr)
            for (int j = 0; j < nb; j++) erd[8*j +: 8] = model[8*(j + lo) +: 8];
        req_valid = 1'b1; req_addr = a; req_size = sz; req_direct = dir;
        req_write = wr; req_wdata = wd;
        #1;
        chk("R2 R3 R4 dev_stb", {31'b0, dev_stb}, {31'b0, acc});
        chk("R6 dev_we", {31'b0, dev_we}, {31'b0, acc && wr});
        chk("R1 lane_en", {28'b0, dev_lane_en}, {28'b0, mask});
        chk("R9 dev_sel", {28'b0, dev_sel}, acc ? (32'd1 << a[5:4]) : 32'd0);
        chk("R9 dev_addr", {16'b0, dev_addr}, acc ? {16'b0, a[15:2], 2'b00} : 32'd0);
        chk("R6 dev_wdata", dev_wdata, ewd);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R2 err_align", {31'b0, rsp_err_align}, {31'b0, mis});
        chk("R3 err_resv", {31'b0, rsp_err_resv}, {31'b0, resv});
        chk("R4 err_range", {31'b0, rsp_err_range}, {31'b0, rng});
        chk("R5 page0", {31'b0, rsp_page0}, {31'b0, a <= 16'h00FF});
        chk("R7 rdata", rsp_rdata, erd);
    endtask

    task automatic sweep(input int lo_a, input int hi_a);
        for (int a = lo_a; a <= hi_a; a++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 2; d++)
                    for (int w = 0; w < 2; w++)
                        do_req(16'(a), 2'(s), d[0], w[0]);
    endtask

    initial begin
        cur_a = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R10 reset flags", {28'b0, rsp_err_align, rsp_err_range, rsp_err_resv, rsp_page0}, 32'd0);
        chk("R10 reset rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        sweep(0, 16'h013F);
        sweep(16'h7FF8, 16'h8007);
        sweep(16'hFFE0, 16'hFFFF);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(64'd8 * 64'd200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule